// File: doc/BRIEF.md
# Nibble-Immediate Register File

This block holds every programmer-visible register of a small 8-bit processor: two 8-bit data registers (A and B), two 16-bit address pointers (P1 and P2), a 16-bit stack pointer (SP) and four status flags (carry, negative, zero and pointers-equal). The processor uses single-byte opcodes only, so constants reach the registers four bits at a time. Half of the opcode space, every byte with its top bit set, is spent on these nibble loads. A load writes its nibble straight into data register A, data register B or pointer P1, without passing through any other register.

The block also takes write-back from two outside sources. An external ALU can write a result into A or B and can update the carry, negative and zero flags. Move logic can copy a value into any of the five registers. The pointers-equal flag is not stored. It follows the comparison of the two pointers in the same cycle.

Top module: `imm_nibble_regfile`

## Requirements
- R1: While `rst_n` is low the registers are cleared at each clock edge: A, B, P1, P2, SP, carry, negative and zero all read 0. Pointers-equal then reads 1, because the two pointers are equal.
- R2: When `op_valid` is 1 and `op_byte[7]` is 1, the next clock edge writes `op_byte[3:0]` into one nibble. `op_byte[6:4]` selects the nibble: 0 A[3:0], 1 A[7:4], 2 B[3:0], 3 B[7:4], 4 P1[3:0], 5 P1[7:4], 6 P1[11:8], 7 P1[15:12]. All other bits of the target keep their value.
- R3: An opcode with `op_byte[7]` = 0, or any opcode while `op_valid` is 0, changes no register.
- R4: An immediate load leaves the carry, negative and zero flags unchanged.
- R5: When `alu_we` is 1, the next edge writes `alu_data` into A if `alu_sel` is 0, or into B if `alu_sel` is 1.
- R6: When `alu_flag_we` is 1, the next edge loads `alu_carry`, `alu_neg` and `alu_zero` into the carry, negative and zero flags.
- R7: When `mov_we` is 1, the next edge writes `mov_data` into the register selected by `mov_dst`: 0 A, 1 B, 2 P1, 3 P2, 4 SP. The data registers take `mov_data[7:0]`. Codes 5 to 7 write nothing.
- R8: `flag_pe` is 1 exactly when P1 equals P2, and it follows pointer changes in the same cycle, with no extra register stage.
- R9: When two sources target the same register in one cycle, the immediate load wins over a move, and a move wins over an ALU write. The losing writes to that register are dropped. Writes to different registers in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Qualifies `op_byte` for this cycle |
| op_byte | input | 8 | Opcode byte being executed |
| alu_we | input | 1 | ALU result write enable |
| alu_sel | input | 1 | ALU result target: 0 A, 1 B |
| alu_data | input | 8 | ALU result |
| alu_flag_we | input | 1 | ALU flag update enable |
| alu_carry | input | 1 | New carry flag |
| alu_neg | input | 1 | New negative flag |
| alu_zero | input | 1 | New zero flag |
| mov_we | input | 1 | Move write enable |
| mov_dst | input | 3 | Move target code |
| mov_data | input | 16 | Move data |
| data_a | output | 8 | Data register A |
| data_b | output | 8 | Data register B |
| ptr1 | output | 16 | Pointer P1, target of immediate loads |
| ptr2 | output | 16 | Pointer P2 |
| stack_ptr | output | 16 | Stack pointer |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_pe | output | 1 | Pointers-equal flag |

## Verification
A sequence of immediate loads visits each of the eight nibble targets, using a different constant for each. The register value is checked after every step. Because each step builds on the previous one, a wrong nibble position, or a load that clobbers the neighbouring nibble, shows up as a wrong accumulated value. Non-load bytes and codes for unused move targets are mixed in to confirm that they leave everything unchanged. Same-cycle collisions of load, move and ALU write, first on one register and then spread over different registers, separate the priority order from simple write loss. Moving a value into P2 that equals P1, and then changing one nibble of P1, shows that pointers-equal follows the pointers in the same cycle.

// File: rtl/imm_regs_pkg.sv
// Package: shared widths, opcode field positions and move target codes
// for the nibble-immediate register file.
// Assumes: 8-bit data registers and 16-bit pointers. The opcode field
// layout is fixed by the single-byte instruction format.
package imm_regs_pkg;

    localparam int DATA_W  = 8;
    localparam int PTR_W   = 16;
    localparam int NIB_W   = 4;
    localparam int DATA_NIBS = DATA_W / NIB_W;
    localparam int PTR_NIBS  = PTR_W / NIB_W;
    localparam int NTGT      = 2 * DATA_NIBS + PTR_NIBS;
    localparam int TGT_W     = $clog2(NTGT);

    // Opcode field positions
    localparam int OP_IMM_BIT = 7;
    localparam int OP_TGT_LSB = 4;
    localparam int OP_NIB_LSB = 0;

    // First nibble-target index of each loadable register
    localparam int TGT_A_BASE  = 0;
    localparam int TGT_B_BASE  = TGT_A_BASE + DATA_NIBS;
    localparam int TGT_P1_BASE = TGT_B_BASE + DATA_NIBS;

    // Move target codes
    typedef enum logic [2:0] {
        MV_A   = 3'd0,
        MV_B   = 3'd1,
        MV_P1  = 3'd2,
        MV_P2  = 3'd3,
        MV_SP  = 3'd4
    } mov_dst_e;

endpackage

// File: rtl/imm_op_decode.sv
// Module: imm_op_decode
// Turns the opcode byte into one nibble-enable per load target, plus the
// nibble value. Also steers the move and ALU write enables onto the five
// registers.
// Assumes: op_valid qualifies op_byte. Only bytes with the top bit set are
// loads. Move codes outside the defined range select nothing.
module imm_op_decode
    import imm_regs_pkg::*;
(
    input  logic                  op_valid,
    input  logic [7:0]            op_byte,
    input  logic                  alu_we,
    input  logic                  alu_sel,
    input  logic                  mov_we,
    input  logic [2:0]            mov_dst,
    output logic [DATA_NIBS-1:0]  imm_en_a,
    output logic [DATA_NIBS-1:0]  imm_en_b,
    output logic [PTR_NIBS-1:0]   imm_en_p1,
    output logic [NIB_W-1:0]      imm_nib,
    output logic                  mov_we_a,
    output logic                  mov_we_b,
    output logic                  mov_we_p1,
    output logic                  mov_we_p2,
    output logic                  mov_we_sp,
    output logic                  alu_we_a,
    output logic                  alu_we_b
);

    logic               is_load;
    logic [TGT_W-1:0]   tgt;
    logic [NTGT-1:0]    tgt_onehot;

    assign is_load = op_valid && op_byte[OP_IMM_BIT];
    assign tgt     = op_byte[OP_TGT_LSB +: TGT_W];
    assign imm_nib = op_byte[OP_NIB_LSB +: NIB_W];

    // Purpose: one enable bit per nibble target, set only for a valid load
    always_comb begin
        tgt_onehot = '0;
        if (is_load) tgt_onehot[tgt] = 1'b1;
    end

    assign imm_en_a  = tgt_onehot[TGT_A_BASE  +: DATA_NIBS];
    assign imm_en_b  = tgt_onehot[TGT_B_BASE  +: DATA_NIBS];
    assign imm_en_p1 = tgt_onehot[TGT_P1_BASE +: PTR_NIBS];

    // Purpose: steer the move enable onto exactly one register, or none
    always_comb begin
        mov_we_a  = 1'b0;
        mov_we_b  = 1'b0;
        mov_we_p1 = 1'b0;
        mov_we_p2 = 1'b0;
        mov_we_sp = 1'b0;
        if (mov_we) begin
            case (mov_dst)
                MV_A:    mov_we_a  = 1'b1;
                MV_B:    mov_we_b  = 1'b1;
                MV_P1:   mov_we_p1 = 1'b1;
                MV_P2:   mov_we_p2 = 1'b1;
                MV_SP:   mov_we_sp = 1'b1;
                default: ;
            endcase
        end
    end

    // Purpose: steer the ALU result enable onto A or B
    always_comb begin
        alu_we_a = alu_we && !alu_sel;
        alu_we_b = alu_we &&  alu_sel;
    end

endmodule

// File: rtl/nib_reg.sv
// Module: nib_reg
// A W-bit register with three write sources in fixed priority. Any
// nibble-immediate enable wins, and only the enabled nibbles change.
// Otherwise a move write is taken, and otherwise an ALU write.
// Assumes: W is a multiple of 4. Unused sources are tied off by the parent.
module nib_reg #(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W/4-1:0]   imm_en,
    input  logic [3:0]       imm_nib,
    input  logic             mov_we,
    input  logic [W-1:0]     mov_data,
    input  logic             alu_we,
    input  logic [W-1:0]     alu_data,
    output logic [W-1:0]     q
);

    localparam int NIBS = W / 4;

    logic [W-1:0] merged;
    logic [W-1:0] next_q;

    // Purpose: build the value with each enabled nibble replaced
    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign merged[g*4 +: 4] = imm_en[g] ? imm_nib : q[g*4 +: 4];
    end

    // Purpose: pick the next value by source priority
    always_comb begin
        if (|imm_en)     next_q = merged;
        else if (mov_we) next_q = mov_data;
        else if (alu_we) next_q = alu_data;
        else             next_q = q;
    end

    // Purpose: state register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= next_q;
    end

endmodule

// File: rtl/flag_unit.sv
// Module: flag_unit
// Holds the carry, negative and zero flags, which only the ALU flag port
// loads. Derives pointers-equal combinationally from the two pointers.
// Assumes: the pointer inputs come straight from their registers.
module flag_unit #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flag_we,
    input  logic          carry_in,
    input  logic          neg_in,
    input  logic          zero_in,
    input  logic [PW-1:0] ptr_x,
    input  logic [PW-1:0] ptr_y,
    output logic          c_q,
    output logic          n_q,
    output logic          z_q,
    output logic          pe
);

    // Purpose: stored arithmetic flags with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= 1'b0;
            n_q <= 1'b0;
            z_q <= 1'b0;
        end else if (flag_we) begin
            c_q <= carry_in;
            n_q <= neg_in;
            z_q <= zero_in;
        end
    end

    // Purpose: live equality of the two pointers
    assign pe = (ptr_x == ptr_y);

endmodule

// File: rtl/imm_nibble_regfile.sv
// Module: imm_nibble_regfile (top)
// The programmer-visible register set: data registers A and B, pointers P1
// and P2, the stack pointer and four status flags. Nibble-immediate loads
// target A, B and P1. Move write-back reaches all five registers, and ALU
// write-back reaches A, B and the arithmetic flags.
// Assumes: a single opcode per cycle. Write collisions on one register are
// resolved inside each register by source priority.
module imm_nibble_regfile
    import imm_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic              alu_we,
    input  logic              alu_sel,
    input  logic [DATA_W-1:0] alu_data,
    input  logic              alu_flag_we,
    input  logic              alu_carry,
    input  logic              alu_neg,
    input  logic              alu_zero,
    input  logic              mov_we,
    input  logic [2:0]        mov_dst,
    input  logic [PTR_W-1:0]  mov_data,
    output logic [DATA_W-1:0] data_a,
    output logic [DATA_W-1:0] data_b,
    output logic [PTR_W-1:0]  ptr1,
    output logic [PTR_W-1:0]  ptr2,
    output logic [PTR_W-1:0]  stack_ptr,
    output logic              flag_c,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_pe
);

    logic [DATA_NIBS-1:0] en_a, en_b;
    logic [PTR_NIBS-1:0]  en_p1;
    logic [NIB_W-1:0]     nib;
    logic mw_a, mw_b, mw_p1, mw_p2, mw_sp;
    logic aw_a, aw_b;

    imm_op_decode u_dec (
        .op_valid  (op_valid),
        .op_byte   (op_byte),
        .alu_we    (alu_we),
        .alu_sel   (alu_sel),
        .mov_we    (mov_we),
        .mov_dst   (mov_dst),
        .imm_en_a  (en_a),
        .imm_en_b  (en_b),
        .imm_en_p1 (en_p1),
        .imm_nib   (nib),
        .mov_we_a  (mw_a),
        .mov_we_b  (mw_b),
        .mov_we_p1 (mw_p1),
        .mov_we_p2 (mw_p2),
        .mov_we_sp (mw_sp),
        .alu_we_a  (aw_a),
        .alu_we_b  (aw_b)
    );

    nib_reg #(.W(DATA_W)) u_reg_a (
        .clk (clk), .rst_n (rst_n),
        .imm_en (en_a), .imm_nib (nib),
        .mov_we (mw_a), .mov_data (mov_data[DATA_W-1:0]),
        .alu_we (aw_a), .alu_data (alu_data),
        .q (data_a)
    );

    nib_reg #(.W(DATA_W)) u_reg_b (
        .clk (clk), .rst_n (rst_n),
        .imm_en (en_b), .imm_nib (nib),
        .mov_we (mw_b), .mov_data (mov_data[DATA_W-1:0]),
        .alu_we (aw_b), .alu_data (alu_data),
        .q (data_b)
    );

    nib_reg #(.W(PTR_W)) u_reg_p1 (
        .clk (clk), .rst_n (rst_n),
        .imm_en (en_p1), .imm_nib (nib),
        .mov_we (mw_p1), .mov_data (mov_data),
        .alu_we (1'b0), .alu_data ('0),
        .q (ptr1)
    );

    nib_reg #(.W(PTR_W)) u_reg_p2 (
        .clk (clk), .rst_n (rst_n),
        .imm_en ('0), .imm_nib ('0),
        .mov_we (mw_p2), .mov_data (mov_data),
        .alu_we (1'b0), .alu_data ('0),
        .q (ptr2)
    );

    nib_reg #(.W(PTR_W)) u_reg_sp (
        .clk (clk), .rst_n (rst_n),
        .imm_en ('0), .imm_nib ('0),
        .mov_we (mw_sp), .mov_data (mov_data),
        .alu_we (1'b0), .alu_data ('0),
        .q (stack_ptr)
    );

    flag_unit #(.PW(PTR_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_we  (alu_flag_we),
        .carry_in (alu_carry),
        .neg_in   (alu_neg),
        .zero_in  (alu_zero),
        .ptr_x    (ptr1),
        .ptr_y    (ptr2),
        .c_q      (flag_c),
        .n_q      (flag_n),
        .z_q      (flag_z),
        .pe       (flag_pe)
    );

endmodule

// File: rtl/imm_nibble_regfile_chk.sv
// Module: imm_nibble_regfile_chk
// Property checker for the register file, attached by bind. It sees only
// the top-level ports.
module imm_nibble_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [7:0]  op_byte,
    input logic        alu_we,
    input logic        alu_sel,
    input logic [7:0]  alu_data,
    input logic        alu_flag_we,
    input logic        alu_carry,
    input logic        alu_neg,
    input logic        alu_zero,
    input logic        mov_we,
    input logic [2:0]  mov_dst,
    input logic [15:0] mov_data,
    input logic [7:0]  data_a,
    input logic [7:0]  data_b,
    input logic [15:0] ptr1,
    input logic [15:0] ptr2,
    input logic [15:0] stack_ptr,
    input logic        flag_c,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_pe
);

    logic quiet;
    assign quiet = !(op_valid && op_byte[7]) && !alu_we && !mov_we;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (data_a == 8'h00 && data_b == 8'h00 && ptr1 == 16'h0 && ptr2 == 16'h0 && stack_ptr == 16'h0 && !flag_c && !flag_n && !flag_z)); // R1

    AST_IMM_A_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte[7:4] == 4'h8) |=> (data_a[3:0] == $past(op_byte[3:0]))); // R2

    AST_IMM_A_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte[7:4] == 4'h8) |=> (data_a[7:4] == $past(data_a[7:4]))); // R2

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ($stable(data_a) && $stable(data_b) && $stable(ptr1) && $stable(ptr2) && $stable(stack_ptr))); // R3

    AST_IMM_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte[7] && !alu_flag_we) |=> ($stable(flag_c) && $stable(flag_n) && $stable(flag_z))); // R4

    AST_ALU_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && alu_sel && !mov_we && !(op_valid && op_byte[7])) |=> (data_b == $past(alu_data))); // R5

    AST_ALU_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        alu_flag_we |=> (flag_c == $past(alu_carry) && flag_n == $past(alu_neg) && flag_z == $past(alu_zero))); // R6

    AST_MOV_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (mov_we && mov_dst == 3'd4) |=> (stack_ptr == $past(mov_data))); // R7

    AST_PE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pe == (ptr1 == ptr2)); // R8

    AST_IMM_BEATS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_byte[7:4] == 4'h8 && mov_we && mov_dst == 3'd0) |=> (data_a[7:4] == $past(data_a[7:4]))); // R9

endmodule

bind imm_nibble_regfile imm_nibble_regfile_chk u_chk (.*);

// File: tb/tb_imm_nibble_regfile.sv
module tb_imm_nibble_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [7:0]  op_byte;
    logic        alu_we, alu_sel;
    logic [7:0]  alu_data;
    logic        alu_flag_we, alu_carry, alu_neg, alu_zero;
    logic        mov_we;
    logic [2:0]  mov_dst;
    logic [15:0] mov_data;
    logic [7:0]  data_a, data_b;
    logic [15:0] ptr1, ptr2, stack_ptr;
    logic        flag_c, flag_n, flag_z, flag_pe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    imm_nibble_regfile dut (.*);

    // Vector: {opcode, expected A, expected B, expected P1}
    localparam int NV = 11;
    localparam logic [39:0] VEC [NV] = '{
        {8'h85, 8'h05, 8'h00, 16'h0000},
        {8'h9C, 8'hC5, 8'h00, 16'h0000},
        {8'hA3, 8'hC5, 8'h03, 16'h0000},
        {8'hBF, 8'hC5, 8'hF3, 16'h0000},
        {8'hC1, 8'hC5, 8'hF3, 16'h0001},
        {8'hD2, 8'hC5, 8'hF3, 16'h0021},
        {8'hE3, 8'hC5, 8'hF3, 16'h0321},
        {8'hF4, 8'hC5, 8'hF3, 16'h4321},
        {8'h37, 8'hC5, 8'hF3, 16'h4321},
        {8'h80, 8'hC0, 8'hF3, 16'h4321},
        {8'hFA, 8'hC0, 8'hF3, 16'hA321}
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        op_valid = 0; op_byte = 0; alu_we = 0; alu_sel = 0; alu_data = 0;
        alu_flag_we = 0; alu_carry = 0; alu_neg = 0; alu_zero = 0;
        mov_we = 0; mov_dst = 0; mov_data = 0;
    endtask

    task automatic chk_all(input string req, input logic [7:0] a, input logic [7:0] b,
                           input logic [15:0] p1, input logic [15:0] p2, input logic [15:0] sp);
        chk(req, "A", {8'h0, data_a}, {8'h0, a});
        chk(req, "B", {8'h0, data_b}, {8'h0, b});
        chk(req, "P1", ptr1, p1);
        chk(req, "P2", ptr2, p2);
        chk(req, "SP", stack_ptr, sp);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_all("R1", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0);
        chk("R1", "flags CNZ", {13'h0, flag_c, flag_n, flag_z}, 16'h0);
        chk("R1", "PE", {15'h0, flag_pe}, 16'h1);
        rst_n = 1'b1;

        // R2/R3: table of nibble loads, one per cycle
        for (int i = 0; i < NV; i++) begin
            op_valid = 1'b1;
            op_byte  = VEC[i][39:32];
            @(negedge clk);
            idle();
            chk(VEC[i][39] ? "R2" : "R3", "A",  {8'h0, data_a}, {8'h0, VEC[i][31:24]});
            chk(VEC[i][39] ? "R2" : "R3", "B",  {8'h0, data_b}, {8'h0, VEC[i][23:16]});
            chk(VEC[i][39] ? "R2" : "R3", "P1", ptr1, VEC[i][15:0]);
        end
        chk("R8", "PE unequal", {15'h0, flag_pe}, 16'h0);

        // R3: valid low with a load byte changes nothing
        op_byte = 8'h8F;
        @(negedge clk);
        idle();
        chk_all("R3", 8'hC0, 8'hF3, 16'hA321, 16'h0, 16'h0);

        // R6: ALU flag load
        alu_flag_we = 1; alu_carry = 1; alu_neg = 0; alu_zero = 1;
        @(negedge clk);
        idle();
        chk("R6", "flags CNZ", {13'h0, flag_c, flag_n, flag_z}, 16'h5);

        // R4: load keeps flags
        op_valid = 1; op_byte = 8'h87;
        @(negedge clk);
        idle();
        chk("R4", "flags CNZ", {13'h0, flag_c, flag_n, flag_z}, 16'h5);
        chk("R2", "A", {8'h0, data_a}, 16'h00C7);

        // R5: ALU write to B
        alu_we = 1; alu_sel = 1; alu_data = 8'h5A;
        @(negedge clk);
        idle();
        chk("R5", "B", {8'h0, data_b}, 16'h005A);
        chk("R5", "A", {8'h0, data_a}, 16'h00C7);

        // R7/R8: move to P2 equal to P1
        mov_we = 1; mov_dst = 3'd3; mov_data = 16'hA321;
        @(negedge clk);
        idle();
        chk("R7", "P2", ptr2, 16'hA321);
        chk("R8", "PE equal", {15'h0, flag_pe}, 16'h1);

        // R8: changing one P1 nibble drops PE
        op_valid = 1; op_byte = 8'hC0;
        @(negedge clk);
        idle();
        chk("R8", "P1", ptr1, 16'hA320);
        chk("R8", "PE", {15'h0, flag_pe}, 16'h0);

        // R7: move to SP, then an undefined code
        mov_we = 1; mov_dst = 3'd4; mov_data = 16'hBEEF;
        @(negedge clk);
        idle();
        chk("R7", "SP", stack_ptr, 16'hBEEF);
        mov_we = 1; mov_dst = 3'd6; mov_data = 16'hFFFF;
        @(negedge clk);
        idle();
        chk_all("R7", 8'hC7, 8'h5A, 16'hA320, 16'hA321, 16'hBEEF);

        // R9: load, move and ALU all on A
        op_valid = 1; op_byte = 8'h82;
        mov_we = 1; mov_dst = 3'd0; mov_data = 16'h0099;
        alu_we = 1; alu_sel = 0; alu_data = 8'h55;
        @(negedge clk);
        idle();
        chk("R9", "A load wins", {8'h0, data_a}, 16'h00C2);

        // R9: move beats ALU on B
        mov_we = 1; mov_dst = 3'd1; mov_data = 16'h0011;
        alu_we = 1; alu_sel = 1; alu_data = 8'h77;
        @(negedge clk);
        idle();
        chk("R9", "B move wins", {8'h0, data_b}, 16'h0011);

        // R9: three sources on three registers
        op_valid = 1; op_byte = 8'hF9;
        mov_we = 1; mov_dst = 3'd0; mov_data = 16'h0066;
        alu_we = 1; alu_sel = 1; alu_data = 8'h44;
        @(negedge clk);
        idle();
        chk_all("R9", 8'h66, 8'h44, 16'h9320, 16'hA321, 16'hBEEF);

        // R7: move to P1
        mov_we = 1; mov_dst = 3'd2; mov_data = 16'h1234;
        @(negedge clk);
        idle();
        chk("R7", "P1", ptr1, 16'h1234);

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0);
        chk("R1", "flags CNZ", {13'h0, flag_c, flag_n, flag_z}, 16'h0);
        chk("R1", "PE", {15'h0, flag_pe}, 16'h1);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule